// File: doc/BRIEF.md
# Timer Clock Select and Divide Unit

This unit derives two timer clocks from a set of oscillator tick strobes. All of it runs in one system clock domain. Each derived clock is a one-cycle enable pulse and is not a real clock edge.

An 8-bit configuration byte chooses the source and the ratio for each derived clock:

- **Capture clock.** It takes the fast internal strobe, the external strobe or the slow internal strobe and divides it by 2, 4, 6 or 8. It can also be switched off.
- **Interval clock.** It takes one of the same three strobes, or the divided capture clock, and divides it by 1 to 4.
- **Interval tick.** A free-running count of capture pulses gives a periodic interval tick.

A change of source is guarded. The new selection is adopted only after the source in use and the requested source have each produced a tick. Until then the divider keeps counting the old source and a busy flag is raised.

A divider that sees its ratio or its active source change restarts from zero. If the interval clock is fed from a capture clock that has been stopped, it cannot leave that source.

Top module: `tmr_clkgen`

## Requirements
- R1: The configuration byte resets to 0x8F and `cfg_rdata` always shows the stored byte. In that byte, bits [7:6] hold the capture ratio, [5:4] the capture source, [3:2] the interval ratio and [1:0] the interval source.
- R2: Capture ratio codes 0, 1, 2 and 3 give one `cap_clk_en` pulse every 2, 4, 6 and 8 ticks of the active capture source. Two capture pulses never fall on adjacent cycles.
- R3: Capture source codes are 0 = fast strobe, 1 = external strobe and 2 = slow strobe. Code 3 turns the capture clock off: once that selection is active, no `cap_clk_en` pulse occurs.
- R4: Interval ratio codes 0, 1, 2 and 3 give one `itv_clk_en` pulse every 1, 2, 3 and 4 ticks of the active interval source.
- R5: Interval source codes are 0 = fast strobe, 1 = external strobe, 2 = slow strobe and 3 = `cap_clk_en`.
- R6: The external strobe is `xtal_tick` while `xtal_en` is 1, and `pin_tick` while it is 0.
- R7: `intv_tick` pulses for one cycle on every 4096th capture pulse, one cycle after that capture pulse.
- R8: A requested source change raises the matching busy output. The switch completes only after the active source and the requested source have each ticked, and until then the divider keeps counting the old source. The active source never changes while busy is low.
- R9: While the interval clock runs from a capture clock that is off, a request to move the interval clock elsewhere stays pending and the interval clock produces no pulse.
- R10: A write stores `cfg_wdata` only when `cfg_we` is 1 and `cfg_addr` equals 0x31. Any other access leaves the byte unchanged.
- R11: When a divider's ratio field or active source changes, its count restarts from zero. After a ratio write with a source ticking every cycle, the first pulse therefore comes a full new period later (ratio 8: nine cycles after the write edge).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_addr | input | ADDR_W | Configuration address |
| cfg_wdata | input | DATA_W | Configuration write data |
| cfg_rdata | output | DATA_W | Stored configuration byte |
| fast_tick | input | 1 | Fast internal oscillator strobe |
| xtal_tick | input | 1 | Crystal oscillator strobe |
| pin_tick | input | 1 | Raw clock-input pin strobe |
| slow_tick | input | 1 | Slow internal oscillator strobe |
| xtal_en | input | 1 | Crystal running; chooses the external strobe |
| cap_clk_en | output | 1 | Divided capture clock pulse |
| itv_clk_en | output | 1 | Divided interval clock pulse |
| intv_tick | output | 1 | Periodic interval tick |
| cap_busy | output | 1 | Capture source switch pending |
| itv_busy | output | 1 | Interval source switch pending |

## Verification
The stimulus uses strobes of different, coprime periods (every cycle, every third, fifth and seventh cycle). A pulse count over a fixed window then reveals both which source a divider really follows and which ratio it applies. Those windows are repeated for every source and ratio code, for both states of `xtal_en`, and for the capture clock turned off.

Some sequences hold the requested source silent, so that a guarded switch cannot complete. One of them strands the interval clock on a stopped capture clock and then releases it. These separate a correct two-sided handshake from one that waits on only one side.

A ratio change under a constant source fixes the restart latency to the cycle. A long run at the fastest capture rate measures the exact spacing of two interval ticks.

// File: rtl/tcg_pkg.sv
`timescale 1ns/1ps
package tcg_pkg;

   localparam logic [1:0] SRC_FAST = 2'd0;
   localparam logic [1:0] SRC_EXT  = 2'd1;
   localparam logic [1:0] SRC_SLOW = 2'd2;
   localparam logic [1:0] SRC_AUX  = 2'd3;   // capture: off, interval: capture clock

   typedef struct packed {
      logic [1:0] cap_div;
      logic [1:0] cap_src;
      logic [1:0] itv_div;
      logic [1:0] itv_src;
   } tcg_cfg_t;

   localparam tcg_cfg_t CFG_RESET = 8'h8F;

   function automatic logic [3:0] cap_ratio(input logic [1:0] code);
      return {1'b0, code, 1'b0} + 4'd2;
   endfunction

   function automatic logic [3:0] itv_ratio(input logic [1:0] code);
      return {2'b00, code} + 4'd1;
   endfunction

endpackage

// File: rtl/tcg_src_switch.sv
`timescale 1ns/1ps
// Guarded source selector: adopts a new selection once both sides have ticked.
module tcg_src_switch #(
   parameter int               SEL_W   = 2,
   parameter logic [SEL_W-1:0] RST_SEL = '0
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic [(1<<SEL_W)-1:0]   tick_vec,
   input  logic [(1<<SEL_W)-1:0]   ready_vec,
   input  logic [SEL_W-1:0]        req_sel,
   output logic [SEL_W-1:0]        act_sel,
   output logic                    busy,
   output logic                    sel_tick
);
   logic [SEL_W-1:0] act_q;
   logic [SEL_W-1:0] tgt_q;
   logic             seen_old_q;
   logic             seen_new_q;
   logic             old_ok;
   logic             new_ok;

   assign old_ok = seen_old_q | ready_vec[act_q];
   assign new_ok = seen_new_q | ready_vec[tgt_q];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         act_q      <= RST_SEL;
         tgt_q      <= RST_SEL;
         seen_old_q <= 1'b0;
         seen_new_q <= 1'b0;
      end else if (req_sel != tgt_q) begin
         tgt_q      <= req_sel;
         seen_old_q <= 1'b0;
         seen_new_q <= 1'b0;
      end else if (act_q != tgt_q) begin
         if (old_ok && new_ok) begin
            act_q      <= tgt_q;
            seen_old_q <= 1'b0;
            seen_new_q <= 1'b0;
         end else begin
            seen_old_q <= old_ok;
            seen_new_q <= new_ok;
         end
      end
   end

   assign act_sel  = act_q;
   assign busy     = (act_q != tgt_q);
   assign sel_tick = tick_vec[act_q];
endmodule

// File: rtl/tcg_pulse_div.sv
`timescale 1ns/1ps
// Tick divider emitting a registered pulse; restarts when ratio or key moves.
module tcg_pulse_div #(
   parameter int               CNT_W     = 4,
   parameter int               KEY_W     = 2,
   parameter logic [KEY_W-1:0] RST_KEY   = '0,
   parameter logic [CNT_W-1:0] RST_RATIO = '1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             tick,
   input  logic [CNT_W-1:0] ratio,
   input  logic [KEY_W-1:0] key,
   output logic             pulse
);
   localparam int SNAP_W = KEY_W + CNT_W;

   logic [CNT_W-1:0]  cnt_q;
   logic [SNAP_W-1:0] snap_q;
   logic [SNAP_W-1:0] snap_now;
   logic              at_end;

   assign snap_now = {key, ratio};
   assign at_end   = (cnt_q == ratio - CNT_W'(1));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q  <= '0;
         snap_q <= {RST_KEY, RST_RATIO};
         pulse  <= 1'b0;
      end else if (snap_now != snap_q) begin
         snap_q <= snap_now;
         cnt_q  <= '0;
         pulse  <= 1'b0;
      end else if (tick) begin
         cnt_q  <= at_end ? '0 : cnt_q + CNT_W'(1);
         pulse  <= at_end;
      end else begin
         pulse  <= 1'b0;
      end
   end
endmodule

// File: rtl/tmr_clkgen.sv
`timescale 1ns/1ps
module tmr_clkgen
   import tcg_pkg::*;
#(
   parameter int                ADDR_W     = 8,
   parameter int                DATA_W     = 8,
   parameter logic [ADDR_W-1:0] CFG_ADDR   = 8'h31,
   parameter int                ITV_PERIOD = 4096
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cfg_we,
   input  logic [ADDR_W-1:0] cfg_addr,
   input  logic [DATA_W-1:0] cfg_wdata,
   output logic [DATA_W-1:0] cfg_rdata,
   input  logic              fast_tick,
   input  logic              xtal_tick,
   input  logic              pin_tick,
   input  logic              slow_tick,
   input  logic              xtal_en,
   output logic              cap_clk_en,
   output logic              itv_clk_en,
   output logic              intv_tick,
   output logic              cap_busy,
   output logic              itv_busy
);
   localparam int DIV_CW   = 4;
   localparam int SEL_W    = 2;
   localparam int N_SRC    = 1 << SEL_W;
   localparam int IVC_W    = $clog2(ITV_PERIOD + 1);
   localparam bit IVC_POW2 = (ITV_PERIOD & (ITV_PERIOD - 1)) == 0;

   if (DATA_W != $bits(tcg_cfg_t)) begin : g_bad_data
      $fatal(1, "DATA_W must match the configuration byte");
   end
   if (ITV_PERIOD < 2) begin : g_bad_period
      $fatal(1, "ITV_PERIOD must be at least 2");
   end

   tcg_cfg_t cfg_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                             cfg_q <= CFG_RESET;
      else if (cfg_we && cfg_addr == CFG_ADDR) cfg_q <= cfg_wdata;
   end
   assign cfg_rdata = cfg_q;

   logic             ext_tick;
   logic [N_SRC-1:0] cap_tick_vec;
   logic [N_SRC-1:0] cap_rdy_vec;
   logic [N_SRC-1:0] itv_tick_vec;
   logic [SEL_W-1:0] cap_act;
   logic [SEL_W-1:0] itv_act;
   logic             cap_src_tick;
   logic             itv_src_tick;

   assign ext_tick     = xtal_en ? xtal_tick : pin_tick;
   assign cap_tick_vec = {1'b0, slow_tick, ext_tick, fast_tick};
   assign cap_rdy_vec  = {1'b1, slow_tick, ext_tick, fast_tick};
   assign itv_tick_vec = {cap_clk_en, slow_tick, ext_tick, fast_tick};

   tcg_src_switch #(.SEL_W(SEL_W), .RST_SEL(CFG_RESET.cap_src)) u_cap_sw (
      .clk(clk), .rst_n(rst_n),
      .tick_vec(cap_tick_vec), .ready_vec(cap_rdy_vec), .req_sel(cfg_q.cap_src),
      .act_sel(cap_act), .busy(cap_busy), .sel_tick(cap_src_tick));

   tcg_pulse_div #(.CNT_W(DIV_CW), .KEY_W(SEL_W), .RST_KEY(CFG_RESET.cap_src),
                   .RST_RATIO(cap_ratio(CFG_RESET.cap_div))) u_cap_div (
      .clk(clk), .rst_n(rst_n), .tick(cap_src_tick),
      .ratio(cap_ratio(cfg_q.cap_div)), .key(cap_act), .pulse(cap_clk_en));

   tcg_src_switch #(.SEL_W(SEL_W), .RST_SEL(CFG_RESET.itv_src)) u_itv_sw (
      .clk(clk), .rst_n(rst_n),
      .tick_vec(itv_tick_vec), .ready_vec(itv_tick_vec), .req_sel(cfg_q.itv_src),
      .act_sel(itv_act), .busy(itv_busy), .sel_tick(itv_src_tick));

   tcg_pulse_div #(.CNT_W(DIV_CW), .KEY_W(SEL_W), .RST_KEY(CFG_RESET.itv_src),
                   .RST_RATIO(itv_ratio(CFG_RESET.itv_div))) u_itv_div (
      .clk(clk), .rst_n(rst_n), .tick(itv_src_tick),
      .ratio(itv_ratio(cfg_q.itv_div)), .key(itv_act), .pulse(itv_clk_en));

   if (IVC_POW2) begin : g_ivc_wrap
      localparam int PW = $clog2(ITV_PERIOD);
      logic [PW-1:0] ivc_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            ivc_q     <= '0;
            intv_tick <= 1'b0;
         end else begin
            if (cap_clk_en) ivc_q <= ivc_q + PW'(1);
            intv_tick <= cap_clk_en && (&ivc_q);
         end
      end
   end else begin : g_ivc_cmp
      tcg_pulse_div #(.CNT_W(IVC_W), .KEY_W(1), .RST_KEY(1'b0),
                      .RST_RATIO(IVC_W'(ITV_PERIOD))) u_ivc (
         .clk(clk), .rst_n(rst_n), .tick(cap_clk_en),
         .ratio(IVC_W'(ITV_PERIOD)), .key(1'b0), .pulse(intv_tick));
   end
endmodule

// File: rtl/tcg_checker.sv
`timescale 1ns/1ps
module tcg_checker #(
   parameter int                ADDR_W   = 8,
   parameter logic [ADDR_W-1:0] CFG_ADDR = 8'h31
) (
   input logic              clk,
   input logic              rst_n,
   input logic              cfg_we,
   input logic [ADDR_W-1:0] cfg_addr,
   input logic [7:0]        cfg_rdata,
   input logic              cap_clk_en,
   input logic              intv_tick,
   input logic [1:0]        cap_act,
   input logic [1:0]        itv_act,
   input logic              cap_busy,
   input logic              itv_busy
);
   assert_no_back2back_R2: assert property (@(posedge clk) disable iff (!rst_n)
      cap_clk_en |=> !cap_clk_en);

   assert_off_silent_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (cap_act == 2'd3) |=> !cap_clk_en);

   assert_tick_follows_cap_R7: assert property (@(posedge clk) disable iff (!rst_n)
      intv_tick |-> $past(cap_clk_en));

   assert_cap_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
      !cap_busy |=> $stable(cap_act));

   assert_itv_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
      !itv_busy |=> $stable(itv_act));

   assert_stranded_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (itv_act == 2'd3 && cap_act == 2'd3 && $past(cap_act) == 2'd3 && !itv_busy)
      |=> (itv_act == 2'd3));

   assert_write_gate_R10: assert property (@(posedge clk) disable iff (!rst_n)
      !(cfg_we && cfg_addr == CFG_ADDR) |=> $stable(cfg_rdata));
endmodule

bind tmr_clkgen tcg_checker #(.ADDR_W(ADDR_W), .CFG_ADDR(CFG_ADDR)) u_tcg_checker (
   .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
   .cfg_rdata(cfg_rdata), .cap_clk_en(cap_clk_en), .intv_tick(intv_tick),
   .cap_act(cap_act), .itv_act(itv_act), .cap_busy(cap_busy), .itv_busy(itv_busy));

// File: tb/tmr_clkgen_bench.sv
`timescale 1ns/1ps
module tmr_clkgen_bench;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       cfg_we = 1'b0;
   logic [7:0] cfg_addr = 8'h00;
   logic [7:0] cfg_wdata = 8'h00;
   logic [7:0] cfg_rdata;
   logic       fast_tick = 1'b0, xtal_tick = 1'b0, pin_tick = 1'b0, slow_tick = 1'b0;
   logic       xtal_en = 1'b1;
   logic       cap_clk_en, itv_clk_en, intv_tick, cap_busy, itv_busy;

   int n_chk = 0, n_err = 0;
   bit done = 0;
   bit cmp_on = 0;
   string tag = "R1";

   // strobe periods in cycles, 0 = silent
   int fast_per = 1, xtal_per = 5, pin_per = 3, slow_per = 7;
   int gcnt = 0;

   always #2.5 clk = ~clk;

   tmr_clkgen u_tmr_clkgen (
      .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
      .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .fast_tick(fast_tick),
      .xtal_tick(xtal_tick), .pin_tick(pin_tick), .slow_tick(slow_tick),
      .xtal_en(xtal_en), .cap_clk_en(cap_clk_en), .itv_clk_en(itv_clk_en),
      .intv_tick(intv_tick), .cap_busy(cap_busy), .itv_busy(itv_busy));

   function automatic bit strobe(int per, int c);
      return (per != 0) && (c % per == 0);
   endfunction

   always @(negedge clk) begin
      gcnt      <= gcnt + 1;
      fast_tick <= strobe(fast_per, gcnt);
      xtal_tick <= strobe(xtal_per, gcnt);
      pin_tick  <= strobe(pin_per, gcnt);
      slow_tick <= strobe(slow_per, gcnt);
   end

   // ---------------- behavioural reference ----------------
   int m_cfg;
   int m_cact, m_ctgt, m_iact, m_itgt;
   bit m_cso, m_csn, m_iso, m_isn;
   int m_ccnt, m_ckey, m_icnt, m_ikey, m_tcnt;
   bit m_cout, m_iout, m_tout;

   function automatic bit pick(int s, bit fb);
      case (s)
         0: return fast_tick;
         1: return xtal_en ? xtal_tick : pin_tick;
         2: return slow_tick;
         default: return fb;
      endcase
   endfunction

   task automatic div_step(input int key, input int r, input bit t,
                           ref int kq, ref int cnt, ref bit out);
      if (key != kq) begin kq = key; cnt = 0; out = 0; end
      else if (t) begin
         if (cnt == r - 1) begin cnt = 0; out = 1; end
         else begin cnt = cnt + 1; out = 0; end
      end else out = 0;
   endtask

   task automatic sw_step(input int req, input bit old_t, input bit new_t,
                          ref int act, ref int tgt, ref bit so, ref bit sn);
      if (req != tgt) begin tgt = req; so = 0; sn = 0; end
      else if (act != tgt) begin
         if ((so | old_t) && (sn | new_t)) begin act = tgt; so = 0; sn = 0; end
         else begin so = so | old_t; sn = sn | new_t; end
      end
   endtask

   always @(posedge clk) begin
      if (!rst_n) begin
         m_cfg = 'h8F; m_cact = 0; m_ctgt = 0; m_iact = 3; m_itgt = 3;
         m_cso = 0; m_csn = 0; m_iso = 0; m_isn = 0;
         m_ccnt = 0; m_icnt = 0; m_tcnt = 0;
         m_ckey = 0 * 16 + 6; m_ikey = 3 * 16 + 4;
         m_cout = 0; m_iout = 0; m_tout = 0;
      end else begin
         automatic bit cap_prev = m_cout;
         automatic int cr = 2 * (((m_cfg >> 6) & 3) + 1);
         automatic int ir = ((m_cfg >> 2) & 3) + 1;
         automatic bit ct = (m_cact == 3) ? 1'b0 : pick(m_cact, 1'b0);
         automatic bit it = pick(m_iact, cap_prev);
         automatic bit c_old = (m_cact == 3) ? 1'b1 : pick(m_cact, 1'b0);
         automatic bit c_new = (m_ctgt == 3) ? 1'b1 : pick(m_ctgt, 1'b0);
         automatic bit i_new = pick(m_itgt, cap_prev);
         div_step(m_cact * 16 + cr, cr, ct, m_ckey, m_ccnt, m_cout);
         div_step(m_iact * 16 + ir, ir, it, m_ikey, m_icnt, m_iout);
         if (cap_prev) begin
            if (m_tcnt == 4095) begin m_tcnt = 0; m_tout = 1; end
            else begin m_tcnt = m_tcnt + 1; m_tout = 0; end
         end else m_tout = 0;
         sw_step((m_cfg >> 4) & 3, c_old, c_new, m_cact, m_ctgt, m_cso, m_csn);
         sw_step(m_cfg & 3, it, i_new, m_iact, m_itgt, m_iso, m_isn);
         if (cfg_we && cfg_addr == 8'h31) m_cfg = cfg_wdata;
      end
   end

   task automatic check(input bit ok, input string req, input string what,
                        input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_err++;
         $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
      end
   endtask

   always @(negedge clk) begin
      if (cmp_on && !done) begin
         check(cap_clk_en == m_cout, tag, "cap_clk_en", cap_clk_en, m_cout);
         check(itv_clk_en == m_iout, tag, "itv_clk_en", itv_clk_en, m_iout);
         check(intv_tick == m_tout, tag, "intv_tick", intv_tick, m_tout);
         check(cap_busy == (m_cact != m_ctgt), tag, "cap_busy", cap_busy, m_cact != m_ctgt);
         check(itv_busy == (m_iact != m_itgt), tag, "itv_busy", itv_busy, m_iact != m_itgt);
         check(cfg_rdata == m_cfg[7:0], tag, "cfg_rdata", cfg_rdata, m_cfg);
      end
   end

   // ---------------- stimulus helpers ----------------
   task automatic wr(input logic [7:0] a, input logic [7:0] d);
      @(negedge clk); cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
      @(negedge clk); cfg_we = 1'b0;
   endtask

   task automatic idle(input int n);
      for (int i = 0; i < n; i++) @(negedge clk);
   endtask

   task automatic count(input int n, output int nc, output int ni);
      nc = 0; ni = 0;
      for (int i = 0; i < n; i++) begin
         @(negedge clk);
         nc += cap_clk_en; ni += itv_clk_en;
      end
   endtask

   task automatic finish_run();
      if (!done) begin
         done = 1;
         $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
         $finish;
      end
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      n_chk++; n_err++;
      $display("FAIL watchdog expired actual=0 expected=1");
      finish_run();
   end

   initial begin
      int nc, ni, idx, gap;
      repeat (4) @(negedge clk);
      rst_n = 1'b1;
      cmp_on = 1;
      @(negedge clk);
      // R1: reset contents
      check(cfg_rdata == 8'h8F, "R1", "reset cfg", cfg_rdata, 'h8F);
      check(cap_busy == 0 && itv_busy == 0, "R1", "reset busy", cap_busy, 0);

      // R2: capture ratios on a fast strobe ticking every cycle
      tag = "R2";
      for (int d = 0; d < 4; d++) begin
         wr(8'h31, 8'((d << 6) | 'h0F));
         idle(24);
         count(48, nc, ni);
         check(nc == 48 / (2 * (d + 1)), "R2", "cap pulses", nc, 48 / (2 * (d + 1)));
      end
      // R11: restart on a ratio change
      tag = "R11";
      wr(8'h31, 8'h8F);
      idle(24);
      wr(8'h31, 8'hCF);
      idx = 0;
      for (int i = 1; i <= 20 && idx == 0; i++) begin
         @(negedge clk);
         if (cap_clk_en) idx = i;
      end
      check(idx == 9, "R11", "first pulse after ratio write", idx, 9);

      // R3: slow source, then off
      tag = "R3";
      wr(8'h31, 8'h2F);
      idle(24);
      count(42, nc, ni);
      check(nc == 3, "R3", "slow /2 pulses", nc, 3);
      // R6: external strobe follows xtal_en
      tag = "R6";
      wr(8'h31, 8'h1F);
      idle(24);
      count(40, nc, ni);
      check(nc == 4, "R6", "xtal /2 pulses", nc, 4);
      xtal_en = 1'b0;
      idle(24);
      count(48, nc, ni);
      check(nc == 8, "R6", "pin /2 pulses", nc, 8);
      xtal_en = 1'b1;
      tag = "R3";
      wr(8'h31, 8'h3F);
      idle(12);
      count(50, nc, ni);
      check(nc == 0, "R3", "off pulses", nc, 0);

      // R4: interval ratios on a fast strobe every third cycle
      tag = "R4";
      fast_per = 3;
      for (int d = 0; d < 4; d++) begin
         wr(8'h31, 8'(d << 2));
         idle(24);
         count(36, nc, ni);
         check(ni == 12 / (d + 1), "R4", "itv pulses", ni, 12 / (d + 1));
      end
      // R5: interval sources
      tag = "R5";
      wr(8'h31, 8'h02);
      idle(24);
      count(35, nc, ni);
      check(ni == 5, "R5", "itv slow pulses", ni, 5);
      wr(8'h31, 8'h01);
      idle(24);
      count(35, nc, ni);
      check(ni == 7, "R5", "itv ext pulses", ni, 7);
      wr(8'h31, 8'h03);
      idle(24);
      count(36, nc, ni);
      check(ni == 6, "R5", "itv from cap pulses", ni, 6);

      // R8: guarded switch to a silent source
      tag = "R8";
      fast_per = 1; slow_per = 0;
      wr(8'h31, 8'h03);
      idle(20);
      wr(8'h31, 8'h23);
      count(20, nc, ni);
      check(cap_busy == 1'b1, "R8", "busy while new source silent", cap_busy, 1);
      check(nc == 10, "R8", "old source still counted", nc, 10);
      slow_per = 7;
      idle(20);
      check(cap_busy == 1'b0, "R8", "busy after both ticked", cap_busy, 0);

      // R9: interval stranded on a stopped capture clock
      tag = "R9";
      wr(8'h31, 8'h03);
      idle(20);
      wr(8'h31, 8'h33);
      idle(20);
      wr(8'h31, 8'h30);
      count(50, nc, ni);
      check(itv_busy == 1'b1, "R9", "itv switch stuck", itv_busy, 1);
      check(ni == 0, "R9", "itv silent", ni, 0);
      check(nc == 0, "R3", "cap silent while off", nc, 0);
      wr(8'h31, 8'h00);
      idle(30);
      check(itv_busy == 1'b0, "R9", "itv released", itv_busy, 0);

      // R10: address gate
      tag = "R10";
      wr(8'h30, 8'h55);
      check(cfg_rdata == 8'h00, "R10", "wrong address ignored", cfg_rdata, 0);
      wr(8'h31, 8'h5A);
      check(cfg_rdata == 8'h5A, "R1", "readback", cfg_rdata, 'h5A);

      // R7: interval tick spacing at capture rate of one pulse per 2 cycles
      tag = "R7";
      wr(8'h31, 8'h03);
      idle(20);
      idx = 0;
      for (int i = 0; i < 9000 && idx == 0; i++) begin
         @(negedge clk);
         if (intv_tick) idx = 1;
      end
      check(idx == 1, "R7", "first interval tick seen", idx, 1);
      gap = 0;
      for (int i = 1; i <= 9000 && gap == 0; i++) begin
         @(negedge clk);
         if (intv_tick) gap = i;
      end
      check(gap == 8192, "R7", "interval tick spacing", gap, 8192);

      idle(4);
      finish_run();
   end
endmodule